// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block lets two ports that share one memory send each other messages and get an interrupt when a message arrives. Both ports reach a common register-file array, and each port owns one mailbox word at the top of the address space. When a port writes into the other port's mailbox, that port's active-low interrupt goes active. The interrupt stays active until its owner reads its own mailbox. The word in the mailbox is plain user data. It is stored and returned unchanged.

Each port has a busy qualifier that comes from an outside arbiter. While a port's busy is high, its mailbox accesses still move data, but they have no effect on the interrupts. A busy write cannot raise the other port's interrupt, and a busy read of its own mailbox cannot clear its own interrupt. The block is fully synchronous and takes one access per port per clock. Read data is registered.

Top module: `dual_port_mailbox`

## Requirements
- R1: While rst_n is low at a clock edge, both interrupt outputs go high (inactive) and both read-data outputs go to zero.
- R2: With address width AW, port 0's mailbox is the address 2^AW-2 and port 1's mailbox is the address 2^AW-1. For the default AW=8 these are 0xFE and 0xFF.
- R3: A non-busy write (sel=1, wr=1) by one port to the other port's mailbox drives the owner's interrupt low after that clock edge.
- R4: A non-busy read (sel=1, wr=0) by a port of its own mailbox drives that port's interrupt high after that clock edge.
- R5: A read by a port of the other port's mailbox leaves the other port's interrupt unchanged.
- R6: While a port's busy is high, its write to the other port's mailbox does not set the other interrupt. The data is still stored.
- R7: While a port's busy is high, its read of its own mailbox does not clear its interrupt. The data is still returned.
- R8: If the same interrupt is set and cleared in the same cycle, the set wins and the interrupt is low after that edge.
- R9: Written data is stored unchanged in the shared array, and either port reads it back on its rdata output one cycle after the read access.
- R10: A write by a port to its own mailbox, or to any address that is not a mailbox, changes neither interrupt.
- R11: If both ports write the same address in one cycle, port 0's data is kept.
- R12: An access with sel=0 writes nothing, changes no interrupt and leaves that port's rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| p0_sel | input | 1 | Port 0 access enable |
| p0_wr | input | 1 | Port 0 direction: 1 = write, 0 = read |
| p0_addr | input | AW | Port 0 word address |
| p0_wdata | input | DW | Port 0 write data |
| p0_busy | input | 1 | Port 0 busy qualifier from the arbiter |
| p0_rdata | output | DW | Port 0 registered read data |
| p0_irq_n | output | 1 | Port 0 interrupt, active low |
| p1_sel | input | 1 | Port 1 access enable |
| p1_wr | input | 1 | Port 1 direction: 1 = write, 0 = read |
| p1_addr | input | AW | Port 1 word address |
| p1_wdata | input | DW | Port 1 write data |
| p1_busy | input | 1 | Port 1 busy qualifier from the arbiter |
| p1_rdata | output | DW | Port 1 registered read data |
| p1_irq_n | output | 1 | Port 1 interrupt, active low |

## Verification
The bench reads the other port's mailbox and expects the interrupt to be untouched. A design that decodes mailbox reads without checking which port owns the mailbox would clear the wrong interrupt here. It drives a clear and a set onto the same interrupt in one cycle. A design with the wrong priority would lose a message and leave the interrupt high. Busy is applied to both the setting write and the clearing read, and the bench checks that the data still moves in both cases. A design that gated the wrong event, or gated storage as well, shows up as a wrong interrupt level or stale read data. Writes to a port's own mailbox, same-address collisions and deselected accesses catch decoders that set interrupts on any mailbox hit, and arrays that let the wrong port win.

// File: rtl/dpmb_pkg.sv
// Shared definitions for the dual-port mailbox block.
// Assumes: two ports, indexed 0 and 1.
package dpmb_pkg;
    // Kind of access a port presents in one cycle.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_t;

    // Number of ports sharing the array.
    localparam int NUM_PORTS = 2;

    // Classify an access from its enable and direction strobes.
    function automatic acc_kind_t classify(input logic sel, input logic wr);
        if (!sel)    return ACC_IDLE;
        else if (wr) return ACC_WRITE;
        else         return ACC_READ;
    endfunction
endpackage

// File: rtl/dpmb_regfile.sv
// Two-port register file shared by both ports.
// Each port has one registered read or one write per clock. Reads return
// the contents from before this edge. When both ports write the same
// address, port 0 wins. The array itself is not reset.
module dpmb_regfile #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we0,
    input  logic          re0,
    input  logic [AW-1:0] addr0,
    input  logic [DW-1:0] wdata0,
    output logic [DW-1:0] rdata0,
    input  logic          we1,
    input  logic          re1,
    input  logic [AW-1:0] addr1,
    input  logic [DW-1:0] wdata1,
    output logic [DW-1:0] rdata1
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic          p1_blocked;

    // Port 1 loses a same-address write collision to port 0.
    assign p1_blocked = we0 && (addr0 == addr1);

    // Store write data from each port.
    always_ff @(posedge clk) begin
        if (we0)               mem[addr0] <= wdata0;
        if (we1 && !p1_blocked) mem[addr1] <= wdata1;
    end

    // Register the read data for each port and hold it between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata0 <= '0;
            rdata1 <= '0;
        end else begin
            if (re0) rdata0 <= mem[addr0];
            if (re1) rdata1 <= mem[addr1];
        end
    end

    // R11: a collision leaves port 0's data, seen by a read of that address
    a_r11_p0_wins_collision: assert property (@(posedge clk) disable iff (!rst_n)
        (we0 && we1 && addr0 == addr1) ##1 (re0 && addr0 == $past(addr0))
        |=> rdata0 == $past(wdata0, 2));
endmodule

// File: rtl/dpmb_decode.sv
// Mailbox access decoder for one port.
// Flags a write to the other port's mailbox, which sets the other port's
// interrupt, and a read of this port's own mailbox, which clears this
// port's interrupt. A busy port produces neither event.
module dpmb_decode
    import dpmb_pkg::*;
#(
    parameter int          AW        = 8,
    parameter logic [AW-1:0] OWN_MBX   = '1,
    parameter logic [AW-1:0] OTHER_MBX = '1
) (
    input  logic          sel,
    input  logic          wr,
    input  logic          busy,
    input  logic [AW-1:0] addr,
    output logic          set_other,
    output logic          clr_own
);
    acc_kind_t kind;

    // Work out the access kind, then qualify each event with busy.
    always_comb begin
        kind      = classify(sel, wr);
        set_other = (kind == ACC_WRITE) && (addr == OTHER_MBX) && !busy;
        clr_own   = (kind == ACC_READ)  && (addr == OWN_MBX)   && !busy;
    end
endmodule

// File: rtl/dpmb_irq_flag.sv
// Active-low interrupt flag for one port.
// Set drives it low and clear drives it high. A set wins over a clear in
// the same cycle. Reset makes it inactive (high).
module dpmb_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq_n
);
    // Update the flag with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)   irq_n <= 1'b1;
        else if (set) irq_n <= 1'b0;
        else if (clr) irq_n <= 1'b1;
    end

    // R1: reset leaves the interrupt inactive
    a_r1_reset_inactive: assert property (@(posedge clk)
        !rst_n |=> irq_n);
    // R3, R8: a set always produces an active interrupt
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> !irq_n);
    // R4: a lone clear releases the interrupt
    a_r4_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> irq_n);
    // R10: with no event the interrupt holds its level
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && !clr) |=> $stable(irq_n));
endmodule

// File: rtl/dual_port_mailbox.sv
// Dual-port shared memory with mailbox interrupts.
// Port 0 owns the mailbox at 2^AW-2 and port 1 owns the one at 2^AW-1.
// A write to the other port's mailbox raises that port's interrupt, and a
// read of a port's own mailbox clears its own interrupt. Busy from the
// outside arbiter blocks both events but not the data movement.
module dual_port_mailbox #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          p0_sel,
    input  logic          p0_wr,
    input  logic [AW-1:0] p0_addr,
    input  logic [DW-1:0] p0_wdata,
    input  logic          p0_busy,
    output logic [DW-1:0] p0_rdata,
    output logic          p0_irq_n,
    input  logic          p1_sel,
    input  logic          p1_wr,
    input  logic [AW-1:0] p1_addr,
    input  logic [DW-1:0] p1_wdata,
    input  logic          p1_busy,
    output logic [DW-1:0] p1_rdata,
    output logic          p1_irq_n
);
    import dpmb_pkg::*;

    localparam logic [AW-1:0] MBX0 = {{(AW-1){1'b1}}, 1'b0};
    localparam logic [AW-1:0] MBX1 = '1;

    logic          sel_v  [NUM_PORTS];
    logic          wr_v   [NUM_PORTS];
    logic          busy_v [NUM_PORTS];
    logic [AW-1:0] addr_v [NUM_PORTS];
    logic          set_other_v [NUM_PORTS];
    logic          clr_own_v   [NUM_PORTS];
    logic          irq_n_v     [NUM_PORTS];

    // Gather the per-port strobes into arrays for the generate loop.
    always_comb begin
        sel_v[0]  = p0_sel;   sel_v[1]  = p1_sel;
        wr_v[0]   = p0_wr;    wr_v[1]   = p1_wr;
        busy_v[0] = p0_busy;  busy_v[1] = p1_busy;
        addr_v[0] = p0_addr;  addr_v[1] = p1_addr;
    end

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        localparam int OTHER = NUM_PORTS - 1 - i;
        localparam logic [AW-1:0] OWN_A   = (i == 0) ? MBX0 : MBX1;
        localparam logic [AW-1:0] OTHER_A = (i == 0) ? MBX1 : MBX0;

        dpmb_decode #(
            .AW        (AW),
            .OWN_MBX   (OWN_A),
            .OTHER_MBX (OTHER_A)
        ) u_decode (
            .sel       (sel_v[i]),
            .wr        (wr_v[i]),
            .busy      (busy_v[i]),
            .addr      (addr_v[i]),
            .set_other (set_other_v[i]),
            .clr_own   (clr_own_v[i])
        );

        dpmb_irq_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_other_v[OTHER]),
            .clr   (clr_own_v[i]),
            .irq_n (irq_n_v[i])
        );
    end

    assign p0_irq_n = irq_n_v[0];
    assign p1_irq_n = irq_n_v[1];

    dpmb_regfile #(
        .AW (AW),
        .DW (DW)
    ) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .we0    (p0_sel && p0_wr),
        .re0    (p0_sel && !p0_wr),
        .addr0  (p0_addr),
        .wdata0 (p0_wdata),
        .rdata0 (p0_rdata),
        .we1    (p1_sel && p1_wr),
        .re1    (p1_sel && !p1_wr),
        .addr1  (p1_addr),
        .wdata1 (p1_wdata),
        .rdata1 (p1_rdata)
    );

    // R3: port 1 writing port 0's mailbox, not busy, raises port 0's interrupt
    a_r3_p1_sets_p0: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_sel && p1_wr && p1_addr == MBX0 && !p1_busy) |=> !p0_irq_n);
    // R6: a busy write by port 0 cannot raise an idle port 1 interrupt
    a_r6_busy_blocks_set: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_sel && p0_wr && p0_addr == MBX1 && p0_busy && p1_irq_n) |=> p1_irq_n);
    // R7: a busy read of its own mailbox leaves port 0's interrupt active
    a_r7_busy_blocks_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_sel && !p0_wr && p0_addr == MBX0 && p0_busy && !p0_irq_n) |=> !p0_irq_n);
    // R5: port 0 reading port 1's mailbox keeps port 1's interrupt active
    a_r5_peek_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_sel && !p0_wr && p0_addr == MBX1 && !p1_irq_n
         && !(p1_sel && !p1_wr && p1_addr == MBX1 && !p1_busy)) |=> !p1_irq_n);
    // R12: a deselected port 0 keeps its read data
    a_r12_idle_holds_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !p0_sel |=> $stable(p0_rdata));
endmodule

// File: tb/dual_port_mailbox_bench.sv
module dual_port_mailbox_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam logic [AW-1:0] MB0 = 8'hFE;
    localparam logic [AW-1:0] MB1 = 8'hFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          p0_sel = 0, p0_wr = 0, p0_busy = 0;
    logic [AW-1:0] p0_addr = '0;
    logic [DW-1:0] p0_wdata = '0;
    logic          p1_sel = 0, p1_wr = 0, p1_busy = 0;
    logic [AW-1:0] p1_addr = '0;
    logic [DW-1:0] p1_wdata = '0;
    logic [DW-1:0] p0_rdata, p1_rdata;
    logic          p0_irq_n, p1_irq_n;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_port_mailbox #(.AW(AW), .DW(DW)) u_dual_port_mailbox (
        .clk(clk), .rst_n(rst_n),
        .p0_sel(p0_sel), .p0_wr(p0_wr), .p0_addr(p0_addr), .p0_wdata(p0_wdata),
        .p0_busy(p0_busy), .p0_rdata(p0_rdata), .p0_irq_n(p0_irq_n),
        .p1_sel(p1_sel), .p1_wr(p1_wr), .p1_addr(p1_addr), .p1_wdata(p1_wdata),
        .p1_busy(p1_busy), .p1_rdata(p1_rdata), .p1_irq_n(p1_irq_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock: inputs were set at a falling edge, sample at the next one.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        p0_sel = 0; p0_wr = 0; p0_busy = 0;
        p1_sel = 0; p1_wr = 0; p1_busy = 0;
    endtask

    task automatic acc0(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic busy);
        p0_sel = 1; p0_wr = wr; p0_addr = a; p0_wdata = d; p0_busy = busy;
    endtask

    task automatic acc1(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic busy);
        p1_sel = 1; p1_wr = wr; p1_addr = a; p1_wdata = d; p1_busy = busy;
    endtask

    task automatic t_reset();
        rst_n = 0;
        step(); step();
        check("R1 p0_irq_n", p0_irq_n, 1);
        check("R1 p1_irq_n", p1_irq_n, 1);
        check("R1 p0_rdata", p0_rdata, 0);
        check("R1 p1_rdata", p1_rdata, 0);
        rst_n = 1;
        step();
    endtask

    task automatic t_data();
        acc0(1, 8'h10, 8'hA5, 0); acc1(1, 8'h11, 8'h5A, 0); step(); idle();
        check("R10 p0_irq_n plain write", p0_irq_n, 1);
        check("R10 p1_irq_n plain write", p1_irq_n, 1);
        acc0(0, 8'h11, 0, 0); acc1(0, 8'h10, 0, 0); step(); idle();
        check("R9 p0 reads p1 data", p0_rdata, 8'h5A);
        check("R9 p1 reads p0 data", p1_rdata, 8'hA5);
    endtask

    task automatic t_set();
        acc1(1, MB0, 8'h3C, 0); step(); idle();
        check("R3 R2 p0_irq_n set", p0_irq_n, 0);
        check("R3 p1_irq_n untouched", p1_irq_n, 1);
        acc0(1, MB1, 8'h7E, 0); step(); idle();
        check("R3 R2 p1_irq_n set", p1_irq_n, 0);
    endtask

    task automatic t_peek();
        acc0(0, MB1, 0, 0); step(); idle();
        check("R5 p1_irq_n after peek", p1_irq_n, 0);
        check("R5 p0 peek data", p0_rdata, 8'h7E);
        acc1(0, MB0, 0, 0); step(); idle();
        check("R5 p0_irq_n after peek", p0_irq_n, 0);
        check("R5 p1 peek data", p1_rdata, 8'h3C);
    endtask

    task automatic t_busy_clear();
        acc0(0, MB0, 0, 1); step(); idle();
        check("R7 p0_irq_n busy read", p0_irq_n, 0);
        check("R7 busy read data", p0_rdata, 8'h3C);
    endtask

    task automatic t_clear();
        acc0(0, MB0, 0, 0); step(); idle();
        check("R4 p0_irq_n cleared", p0_irq_n, 1);
        check("R4 p0 mailbox data", p0_rdata, 8'h3C);
        acc1(0, MB1, 0, 0); step(); idle();
        check("R4 p1_irq_n cleared", p1_irq_n, 1);
    endtask

    task automatic t_busy_set();
        acc1(1, MB0, 8'h99, 1); step(); idle();
        check("R6 p0_irq_n busy write", p0_irq_n, 1);
        acc0(0, MB0, 0, 0); step(); idle();
        check("R6 busy write stored", p0_rdata, 8'h99);
    endtask

    task automatic t_own();
        acc0(1, MB0, 8'h12, 0); acc1(1, MB1, 8'h34, 0); step(); idle();
        check("R10 p0_irq_n own write", p0_irq_n, 1);
        check("R10 p1_irq_n own write", p1_irq_n, 1);
    endtask

    task automatic t_race();
        acc1(1, MB0, 8'h01, 0); step(); idle();
        check("R3 p0_irq_n before race", p0_irq_n, 0);
        acc0(0, MB0, 0, 0); acc1(1, MB0, 8'h02, 0); step(); idle();
        check("R8 set wins", p0_irq_n, 0);
        check("R8 read sees old data", p0_rdata, 8'h01);
        acc0(0, MB0, 0, 0); step(); idle();
        check("R8 later clear", p0_irq_n, 1);
        check("R8 new data", p0_rdata, 8'h02);
    endtask

    task automatic t_collide();
        acc0(1, 8'h30, 8'hC0, 0); acc1(1, 8'h30, 8'hD1, 0); step(); idle();
        acc1(0, 8'h30, 0, 0); step(); idle();
        check("R11 port 0 wins", p1_rdata, 8'hC0);
    endtask

    task automatic t_desel();
        p1_sel = 0; p1_wr = 1; p1_addr = MB0; p1_wdata = 8'hEE;
        p0_sel = 0; p0_wr = 0; p0_addr = 8'h30;
        step(); idle();
        check("R12 p0_irq_n deselected", p0_irq_n, 1);
        check("R12 p0_rdata held", p0_rdata, 8'h02);
        acc0(0, MB0, 0, 0); step(); idle();
        check("R12 no write", p0_rdata, 8'h02);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_data();
        t_set();
        t_peek();
        t_busy_clear();
        t_clear();
        t_busy_set();
        t_own();
        t_race();
        t_collide();
        t_desel();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule